// File: doc/BRIEF.md
# Budgeted Peripheral Traffic Scheduler

This block decides which of several bus-mastering peripheral bridges may move data to main memory in each clock cycle. Every bridge raises a ready line while it holds buffered data. The scheduler answers with one hold-off line per bridge. A held bridge stays off the shared bus. At most one bridge is released at any time, so two DMA streams never contend for memory inside the arbiter of the bus.

Each channel has its own timing server with a budget and a replenishment period. A channel competes only while it has data and while its server has budget left. Among the competing channels, a strict fixed-priority chain releases the one with the lowest index. Every cycle in which a channel is released costs one unit of its budget. When the period counter of a channel runs out, its budget and its period counter are both reloaded from configuration.

A master enable selects between two operating modes. With the enable low, the block is in bypass: every hold-off line is low, bridges contend freely, and budget/period values may be written. With the enable high, the block passes through a one-cycle arming state and then schedules. The mode machine has three states. MODE_BYPASS goes to MODE_ARM when the enable is high. MODE_ARM goes to MODE_RUN when the enable stays high, or back to MODE_BYPASS when it drops. MODE_RUN goes to MODE_BYPASS when the enable drops. Each per-channel server also has three states. SRV_IDLE holds outside scheduling. SRV_ACTIVE means budget remains. SRV_SPENT means the budget is exhausted until the next replenishment. The server moves from SRV_IDLE to SRV_ACTIVE or SRV_SPENT on the load, from SRV_ACTIVE to SRV_SPENT when its last unit is used, back to SRV_ACTIVE on a replenishment with a nonzero budget, and to SRV_IDLE whenever scheduling stops.

Top module: `periph_traffic_sched`

## Requirements
- R1: During reset and after it, while the enable stays low, the block is in MODE_BYPASS and every bit of `block` is 0.
- R2: In MODE_BYPASS every bit of `block` is 0, whatever `data_rdy` is.
- R3: A `cfg_we` pulse sampled in MODE_BYPASS with `sched_en` low stores `cfg_budget` and `cfg_period` for channel `cfg_sel`. At any other time `cfg_we` has no effect on the stored values.
- R4: The first clock edge with `sched_en` high in MODE_BYPASS enters MODE_ARM. For that one cycle every bit of `block` is 1, and all servers load their budget and period. The next edge enters MODE_RUN.
- R5: In MODE_RUN at most one bit of `block` is 0. A channel is unblocked only while its `data_rdy` is 1 and its server has budget.
- R6: In MODE_RUN the released channel is the lowest-indexed one that is eligible. Channel 0 has the highest priority, and every other channel is blocked while a lower index is eligible.
- R7: Each cycle in which a channel is released consumes one unit of budget. When a channel uses its last unit, it is blocked from the next cycle on, even with `data_rdy` held high.
- R8: A channel with period P replenishes its budget after every P cycles in MODE_RUN, counted from the first cycle of MODE_RUN. A period of 0 behaves as a period of 1.
- R9: A channel configured with a budget of 0 is never released in MODE_RUN.
- R10: When `sched_en` is low at a clock edge in MODE_RUN, the block is in MODE_BYPASS from that edge on, with every bit of `block` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sched_en | input | 1 | 1 = schedule traffic, 0 = bypass with configuration access |
| cfg_we | input | 1 | Write strobe for the budget and period of one channel |
| cfg_sel | input | SEL_W (2) | Channel index addressed by the write |
| cfg_budget | input | CNT_W (16) | Budget value, in cycles of release per period |
| cfg_period | input | CNT_W (16) | Replenishment period, in cycles |
| data_rdy | input | NUM_CH (4) | Per-bridge indication that buffered data is waiting |
| block | output | NUM_CH (4) | Per-bridge hold-off; 1 keeps the bridge off the bus |

## Verification
The assertions assume that `cfg_sel` always addresses an existing channel. They also assume that the stored configuration changes only through the bypass-mode write path, because the servers read the stored budget again at each replenishment. The bench issues every configuration write with `sched_en` low, except for one write that deliberately arrives during MODE_RUN, and only with channel indices in range. It changes `data_rdy` and `sched_en` at the falling clock edge only, so each input is stable around the sampling edge. Budget and period values are kept small so that exhaustion and replenishment fall within a short window of cycles.

// File: rtl/pts_pkg.sv
package pts_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_ARM    = 2'd1,
        MODE_RUN    = 2'd2
    } mode_state_t;

    typedef enum logic [1:0] {
        SRV_IDLE   = 2'd0,
        SRV_ACTIVE = 2'd1,
        SRV_SPENT  = 2'd2
    } srv_state_t;

endpackage

// File: rtl/pts_mode_fsm.sv
module pts_mode_fsm
    import pts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sched_en,
    output logic in_bypass,
    output logic in_arm,
    output logic in_run
);

    mode_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BYPASS: if (sched_en)  state_d = MODE_ARM;
            MODE_ARM:    state_d = sched_en ? MODE_RUN : MODE_BYPASS;
            MODE_RUN:    if (!sched_en) state_d = MODE_BYPASS;
            default:     state_d = MODE_BYPASS;
        endcase
    end

    always_comb begin
        in_bypass = (state_q == MODE_BYPASS);
        in_arm    = (state_q == MODE_ARM);
        in_run    = (state_q == MODE_RUN);
    end

endmodule

// File: rtl/pts_server.sv
module pts_server
    import pts_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             exec,
    input  logic [CNT_W-1:0] cfg_budget,
    input  logic [CNT_W-1:0] cfg_period,
    output logic             has_budget
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    srv_state_t       state_q, state_d;
    logic [CNT_W-1:0] budget_q;
    logic [CNT_W-1:0] period_q;
    logic             replenish;
    logic             cfg_nonzero;

    assign replenish   = run && (period_q <= ONE);
    assign cfg_nonzero = (cfg_budget != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRV_IDLE: begin
                if (load) state_d = cfg_nonzero ? SRV_ACTIVE : SRV_SPENT;
            end
            SRV_ACTIVE: begin
                if (!run)                          state_d = SRV_IDLE;
                else if (replenish)                state_d = cfg_nonzero ? SRV_ACTIVE : SRV_SPENT;
                else if (exec && budget_q == ONE)  state_d = SRV_SPENT;
            end
            SRV_SPENT: begin
                if (!run)                          state_d = SRV_IDLE;
                else if (replenish && cfg_nonzero) state_d = SRV_ACTIVE;
            end
            default: state_d = SRV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            budget_q <= '0;
            period_q <= '0;
        end else if (load) begin
            budget_q <= cfg_budget;
            period_q <= cfg_period;
        end else if (run) begin
            if (replenish) begin
                budget_q <= cfg_budget;
                period_q <= cfg_period;
            end else begin
                period_q <= period_q - ONE;
                if (exec && budget_q != '0) budget_q <= budget_q - ONE;
            end
        end
    end

    assign has_budget = (state_q == SRV_ACTIVE);

endmodule

// File: rtl/pts_prio_chain.sv
module pts_prio_chain #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] ready,
    output logic [NUM_CH-1:0] exec
);

    logic [NUM_CH:0] taken;

    assign taken[0] = 1'b0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_link
        assign exec[g]    = ready[g] & ~taken[g];
        assign taken[g+1] = taken[g] | ready[g];
    end

endmodule

// File: rtl/periph_traffic_sched.sv
module periph_traffic_sched
    import pts_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_en,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CNT_W-1:0]  cfg_budget,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [NUM_CH-1:0] data_rdy,
    output logic [NUM_CH-1:0] block
);

    logic                          mode_bypass;
    logic                          mode_arm;
    logic                          mode_run;
    logic [NUM_CH-1:0]             has_budget;
    logic [NUM_CH-1:0]             ready;
    logic [NUM_CH-1:0]             exec;
    logic [NUM_CH-1:0][CNT_W-1:0]  cfg_bud_q;
    logic [NUM_CH-1:0][CNT_W-1:0]  cfg_per_q;
    logic                          cfg_open;

    pts_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sched_en  (sched_en),
        .in_bypass (mode_bypass),
        .in_arm    (mode_arm),
        .in_run    (mode_run)
    );

    assign cfg_open = cfg_we && mode_bypass && !sched_en;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_bud_q[g] <= '0;
                cfg_per_q[g] <= '0;
            end else if (cfg_open && cfg_sel == SEL_W'(g)) begin
                cfg_bud_q[g] <= cfg_budget;
                cfg_per_q[g] <= cfg_period;
            end
        end

        pts_server #(.CNT_W(CNT_W)) u_srv (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (mode_arm),
            .run        (mode_run),
            .exec       (exec[g]),
            .cfg_budget (cfg_bud_q[g]),
            .cfg_period (cfg_per_q[g]),
            .has_budget (has_budget[g])
        );
    end

    assign ready = data_rdy & has_budget & {NUM_CH{mode_run}};

    pts_prio_chain #(.NUM_CH(NUM_CH)) u_prio (
        .ready (ready),
        .exec  (exec)
    );

    always_comb begin
        if (mode_run)      block = ~exec;
        else if (mode_arm) block = '1;
        else               block = '0;
    end

endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sched_en,
    input logic [NUM_CH-1:0]            data_rdy,
    input logic [NUM_CH-1:0]            block,
    input logic                         mode_run,
    input logic                         mode_bypass,
    input logic [NUM_CH-1:0]            has_budget,
    input logic [NUM_CH-1:0][CNT_W-1:0] cfg_bud,
    input logic [NUM_CH-1:0][CNT_W-1:0] cfg_per
);

    // R2
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bypass |-> (block == '0));

    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_run |-> $onehot0(~block));

    // R5
    owner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_run |-> ((~block & ~(data_rdy & has_budget)) == '0));

    // R6
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_run && data_rdy[0] && has_budget[0]) |-> !block[0]);

    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bypass |=> ($stable(cfg_bud) && $stable(cfg_per)));

    // R10
    leave_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_run && !sched_en) |=> mode_bypass);

endmodule

bind periph_traffic_sched pts_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sched_en    (sched_en),
    .data_rdy    (data_rdy),
    .block       (block),
    .mode_run    (mode_run),
    .mode_bypass (mode_bypass),
    .has_budget  (has_budget),
    .cfg_bud     (cfg_bud_q),
    .cfg_per     (cfg_per_q)
);

// File: tb/periph_traffic_sched_bench.sv
module periph_traffic_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_budget = '0;
    logic [15:0] cfg_period = '0;
    logic [3:0]  data_rdy = '0;
    logic [3:0]  block;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    periph_traffic_sched u_periph_traffic_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .sched_en   (sched_en),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_budget (cfg_budget),
        .cfg_period (cfg_period),
        .data_rdy   (data_rdy),
        .block      (block)
    );

    // {data_rdy, expected block} pairs for R5/R6 with ample budgets
    localparam logic [7:0] VEC [8] = '{
        8'b0000_1111, 8'b0001_1110, 8'b0110_1101, 8'b1100_1011,
        8'b1000_0111, 8'b1111_1110, 8'b1010_1101, 8'b0100_1011
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: block actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input int ch, input int b, input int p);
        cfg_we = 1'b1;
        cfg_sel = 2'(ch);
        cfg_budget = 16'(b);
        cfg_period = 16'(p);
        step();
        cfg_we = 1'b0;
    endtask

    // enable, check the arming cycle (R4), land on run cycle 0
    task automatic start_run();
        sched_en = 1'b1;
        step();
        check("R4 arm cycle", block, 4'b1111);
        step();
    endtask

    task automatic stop_run();
        sched_en = 1'b0;
        step();
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        data_rdy = 4'b1111;
        #1 check("R1 during reset", block, 4'b0000);
        step();
        rst_n = 1'b1;
        step();
        check("R1 after reset", block, 4'b0000);
        data_rdy = 4'b0101;
        #1 check("R2 bypass ignores data_rdy", block, 4'b0000);

        // table walk: R5, R6
        for (int c = 0; c < 4; c++) write_cfg(c, 50, 100);
        data_rdy = 4'b0000;
        start_run();
        for (int i = 0; i < 8; i++) begin
            data_rdy = VEC[i][7:4];
            #1 check($sformatf("R6 vector %0d", i), block, VEC[i][3:0]);
            step();
        end
        data_rdy = 4'b1111;
        stop_run();
        check("R10 back to bypass", block, 4'b0000);

        // exhaustion, replenish, zero budget, ignored write: R7 R8 R9 R3
        write_cfg(0, 3, 8);
        write_cfg(1, 0, 8);
        write_cfg(2, 0, 8);
        write_cfg(3, 0, 8);
        data_rdy = 4'b0011;
        start_run();
        for (int k = 0; k < 12; k++) begin
            if (k == 0) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_budget = 16'd7; cfg_period = 16'd8;
            end else begin
                cfg_we = 1'b0;
            end
            #1 check($sformatf("R7 R8 R9 R3 run cycle %0d", k), block,
                     ((k < 3) || (k >= 8 && k < 11)) ? 4'b1110 : 4'b1111);
            step();
        end
        stop_run();

        // fall-through to the next priority once channel 0 is spent: R6 R7
        write_cfg(0, 2, 8);
        write_cfg(1, 4, 8);
        data_rdy = 4'b0011;
        start_run();
        for (int k = 0; k < 9; k++) begin
            logic [3:0] e;
            if (k < 2 || k == 8) e = 4'b1110;
            else if (k < 6)      e = 4'b1101;
            else                 e = 4'b1111;
            #1 check($sformatf("R6 R7 fall-through cycle %0d", k), block, e);
            step();
        end
        stop_run();

        // period 0 acts as period 1: R8
        write_cfg(0, 1, 0);
        write_cfg(1, 0, 8);
        data_rdy = 4'b0001;
        start_run();
        for (int k = 0; k < 4; k++) begin
            #1 check($sformatf("R8 zero period cycle %0d", k), block, 4'b1110);
            step();
        end
        stop_run();
        check("R10 bypass after stop", block, 4'b0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule